// File: doc/BRIEF.md
# Frame Sync Alignment Counter

This block keeps track of where a transmit serial stream sits inside its frame. A position counter advances once per serial clock and wraps at a frame length set by a mode code: 193, 256, 512 or 1024 clocks. Two strobes are decoded from the position. One marks the first clock of each frame. The other marks the first clock of each byte. In the 193-clock mode the byte grid starts one bit late, so that the lone framing bit is left out.

An external sync pulse, one clock wide, forces the counter onto a known frame boundary. A polarity setting selects whether the pulse is active high or active low. A lead setting states how early the pulse comes before the frame start: 0, 1/2, 1 or 2 clocks. The lead setting and a clock-inversion setting together select the clock edge that samples the pulse. A single pulse is enough. After it the counter free-runs and stays aligned. If the sync line never goes active, the counter runs freely from reset.

Cycle k is the clock period that begins at rising edge k. The bench drives a full-width pulse from a quarter period after rising edge k until a quarter period after rising edge k+1. Such a pulse covers both possible sampling edges.

Top module: `frame_sync_align`

## Requirements
- R1: While reset is held and on release, bit_pos is 0 and frame_stb is 1. byte_stb is 1 in the modes other than 193 clocks and 0 in the 193-clock mode.
- R2: The mode code selects the frame length N: 00 gives 193, 01 gives 256, 10 gives 512 and 11 gives 1024. bit_pos runs from 0 to N-1 and then returns to 0.
- R3: frame_stb is 1 in exactly those cycles where bit_pos is 0.
- R4: In modes 01, 10 and 11, byte_stb is 1 exactly when bit_pos modulo 8 is 0.
- R5: In mode 00, byte_stb is 1 exactly when bit_pos modulo 8 is 1, that is at positions 1, 9, ..., 185. It is 0 at position 0 and at position 192.
- R6: While the sync line stays inactive, bit_pos counts up by one every clock from 0 after reset, with no jumps.
- R7: The lead code sets a lead D of 0, 1, 1 or 2 clocks for codes 00 (none), 01 (half clock), 10 (one clock) and 11 (two clocks). For a pulse detected in cycle k, bit_pos in cycle k+2 equals 2-D. Position 0 therefore falls on cycle k+D modulo the frame.
- R8: cfg_sync_low = 0 makes a high level on sync_in the active pulse. cfg_sync_low = 1 makes a low level active, and a steady high level then causes no alignment.
- R9: The pulse is sampled at the falling edge inside cycle k, with two exceptions. It is sampled at the rising edge that ends cycle k when cfg_clk_inv = 0 with lead code 11, or when cfg_clk_inv = 1 with any lead code other than 00. A pulse present only at the edge that is not selected has no effect on bit_pos.
- R10: After one pulse, alignment holds across later frame wraps with no further pulses.
- R11: A later pulse realigns the counter from any position, under the same rule as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Frame length code (00/01/10/11 = 193/256/512/1024) |
| cfg_sync_low | input | 1 | 1: sync pulse is active low |
| cfg_clk_inv | input | 1 | 1: serial clock is run inverted (changes the sampling edge) |
| cfg_lead | input | 2 | Pulse lead code (0, 1/2, 1, 2 clocks) |
| sync_in | input | 1 | External frame sync pulse |
| bit_pos | output | POS_W | Bit position within the frame |
| byte_stb | output | 1 | First clock of a byte |
| frame_stb | output | 1 | First clock of a frame |

## Verification
A wrong position register shows up on bit_pos in the same cycle. A wrong wrap compare shows up at the latest one frame later, when bit_pos runs past N-1 or returns to 0 too early. A wrong edge select or a wrong load value leaves the frame start offset by one or two clocks. This is visible two cycles after the pulse and in every frame after that. The sweeps compare every cycle against an arithmetic count, so any such offset is caught within one frame.

// File: rtl/fsa_pkg.sv
`timescale 1ns/1ps
package fsa_pkg;

   typedef enum logic [1:0] {
      FM_T1 = 2'b00,
      FM_E1 = 2'b01,
      FM_4M = 2'b10,
      FM_8M = 2'b11
   } fsa_mode_e;

   typedef enum logic [1:0] {
      LEAD_NONE = 2'b00,
      LEAD_HALF = 2'b01,
      LEAD_ONE  = 2'b10,
      LEAD_TWO  = 2'b11
   } fsa_lead_e;

   // cycles from the pulse cycle to the cycle holding the loaded position
   localparam int DET_LAT = 2;

   // whole-clock lead of the frame start after the pulse cycle
   function automatic int lead_dist(input logic [1:0] lead);
      case (lead)
         LEAD_NONE: return 0;
         LEAD_TWO:  return 2;
         default:   return 1;
      endcase
   endfunction

   // 1 when the rising edge samples the pulse
   function automatic logic rise_selected(input logic clk_inv, input logic [1:0] lead);
      if (clk_inv) return (lead != LEAD_NONE);
      return (lead == LEAD_TWO);
   endfunction

endpackage

// File: rtl/fsa_sync_sampler.sv
`timescale 1ns/1ps
module fsa_sync_sampler
   import fsa_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_low,
   input  logic       clk_inv,
   input  logic [1:0] lead,
   input  logic       sync_in,
   output logic       det
);

   logic act;
   logic fall_q;
   logic fall_r;
   logic rise_q;
   logic use_rise;

   assign act = sync_in ^ sync_low;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= act;
   end

   // retime the falling sample so that both paths have equal latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_r <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         fall_r <= fall_q;
         rise_q <= act;
      end
   end

   always_comb use_rise = rise_selected(clk_inv, lead);
   assign det = use_rise ? rise_q : fall_r;

endmodule

// File: rtl/fsa_frame_counter.sv
`timescale 1ns/1ps
module fsa_frame_counter
   import fsa_pkg::*;
#(
   parameter int POS_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] frame_last,
   input  logic [1:0]       lead,
   input  logic             det,
   output logic [POS_W-1:0] pos
);

   logic [POS_W-1:0] load_val;
   logic [POS_W-1:0] pos_nxt;

   always_comb load_val = POS_W'(DET_LAT - lead_dist(lead));

   always_comb begin
      if (det)                    pos_nxt = load_val;
      else if (pos >= frame_last) pos_nxt = '0;
      else                        pos_nxt = pos + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= pos_nxt;
   end

endmodule

// File: rtl/fsa_strobe_gen.sv
`timescale 1ns/1ps
module fsa_strobe_gen #(
   parameter int POS_W     = 10,
   parameter int BYTE_BITS = 8,
   parameter int T1_OFS    = 1
) (
   input  logic [POS_W-1:0] pos,
   input  logic             is_t1,
   output logic             byte_stb,
   output logic             frame_stb
);

   localparam int LSB_W = $clog2(BYTE_BITS);

   generate
      if ((1 << LSB_W) != BYTE_BITS) begin : g_bad_byte
         $error("BYTE_BITS must be a power of two");
      end
      if (T1_OFS >= BYTE_BITS || T1_OFS < 1) begin : g_bad_ofs
         $error("T1_OFS must lie inside one byte and be nonzero");
      end
   endgenerate

   logic [LSB_W-1:0] low;
   logic             at_zero;

   assign low     = pos[LSB_W-1:0];
   assign at_zero = (pos == '0);

   always_comb begin
      frame_stb = at_zero;
      if (is_t1) byte_stb = (low == LSB_W'(T1_OFS)) && !at_zero;
      else       byte_stb = (low == '0);
   end

endmodule

// File: rtl/frame_sync_align.sv
`timescale 1ns/1ps
module frame_sync_align
   import fsa_pkg::*;
#(
   parameter int POS_W     = 10,
   parameter int LEN_T1    = 193,
   parameter int LEN_E1    = 256,
   parameter int LEN_4M    = 512,
   parameter int LEN_8M    = 1024,
   parameter int BYTE_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_sync_low,
   input  logic             cfg_clk_inv,
   input  logic [1:0]       cfg_lead,
   input  logic             sync_in,
   output logic [POS_W-1:0] bit_pos,
   output logic             byte_stb,
   output logic             frame_stb
);

   localparam int MAX_LEN = (LEN_8M > LEN_4M) ? LEN_8M : LEN_4M;

   generate
      if (POS_W < $clog2(MAX_LEN)) begin : g_bad_width
         $error("POS_W too narrow for the longest frame");
      end
      if (LEN_T1 <= DET_LAT || LEN_E1 <= DET_LAT || LEN_4M <= DET_LAT || LEN_8M <= DET_LAT)
      begin : g_bad_len
         $error("frame lengths must exceed the detect latency");
      end
      if (LEN_T1 > MAX_LEN || LEN_E1 > MAX_LEN) begin : g_bad_order
         $error("short frame modes must not exceed the long ones");
      end
   endgenerate

   logic [POS_W-1:0] frame_last;
   logic             sync_det;
   logic             is_t1;

   always_comb begin
      case (fsa_mode_e'(cfg_mode))
         FM_T1:   frame_last = POS_W'(LEN_T1 - 1);
         FM_E1:   frame_last = POS_W'(LEN_E1 - 1);
         FM_4M:   frame_last = POS_W'(LEN_4M - 1);
         default: frame_last = POS_W'(LEN_8M - 1);
      endcase
   end

   assign is_t1 = (cfg_mode == FM_T1);

   fsa_sync_sampler u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_low (cfg_sync_low),
      .clk_inv  (cfg_clk_inv),
      .lead     (cfg_lead),
      .sync_in  (sync_in),
      .det      (sync_det)
   );

   fsa_frame_counter #(.POS_W(POS_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_last (frame_last),
      .lead       (cfg_lead),
      .det        (sync_det),
      .pos        (bit_pos)
   );

   fsa_strobe_gen #(.POS_W(POS_W), .BYTE_BITS(BYTE_BITS), .T1_OFS(1)) u_strobe (
      .pos       (bit_pos),
      .is_t1     (is_t1),
      .byte_stb  (byte_stb),
      .frame_stb (frame_stb)
   );

endmodule

// File: rtl/fsa_align_checker.sv
`timescale 1ns/1ps
module fsa_align_checker #(
   parameter int POS_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [1:0]       lead,
   input logic             det,
   input logic [POS_W-1:0] bit_pos,
   input logic [POS_W-1:0] frame_last,
   input logic             byte_stb,
   input logic             frame_stb
);

   logic [POS_W-1:0] load_exp;

   always_comb begin
      case (lead)
         2'b00:   load_exp = POS_W'(2);
         2'b11:   load_exp = '0;
         default: load_exp = POS_W'(1);
      endcase
   end

   // R2
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!det && bit_pos == frame_last) |=> bit_pos == '0);

   // R6
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!det && bit_pos < frame_last) |=> bit_pos == $past(bit_pos) + 1'b1);

   // R7
   sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det |=> bit_pos == $past(load_exp));

   // R3
   frame_only_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> bit_pos == '0);

   // R3
   zero_gives_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_pos == '0 |-> frame_stb);

   // R4
   byte_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && mode != 2'b00) |-> bit_pos[2:0] == 3'd0);

   // R5
   t1_byte_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && mode == 2'b00) |-> (bit_pos[2:0] == 3'd1 && bit_pos != '0));

endmodule

bind frame_sync_align fsa_align_checker #(.POS_W(POS_W)) u_align_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (cfg_mode),
   .lead       (cfg_lead),
   .det        (sync_det),
   .bit_pos    (bit_pos),
   .frame_last (frame_last),
   .byte_stb   (byte_stb),
   .frame_stb  (frame_stb)
);

// File: tb/frame_sync_align_test.sv
`timescale 1ns/1ps
module frame_sync_align_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b01;
   logic       cfg_sync_low = 1'b0;
   logic       cfg_clk_inv = 1'b0;
   logic [1:0] cfg_lead = 2'b00;
   logic       sync_in = 1'b0;
   logic [9:0] bit_pos;
   logic       byte_stb;
   logic       frame_stb;

   int checks = 0;
   int fails  = 0;
   int cnum, exp_pos, n_len, load_at, load_v;

   always #10 clk = ~clk;

   frame_sync_align uut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_sync_low(cfg_sync_low),
      .cfg_clk_inv(cfg_clk_inv), .cfg_lead(cfg_lead), .sync_in(sync_in),
      .bit_pos(bit_pos), .byte_stb(byte_stb), .frame_stb(frame_stb)
   );

   function automatic int len_of(input logic [1:0] m);
      case (m)
         2'b00: return 193;
         2'b01: return 256;
         2'b10: return 512;
         default: return 1024;
      endcase
   endfunction

   function automatic int dist_of(input logic [1:0] l);
      case (l)
         2'b00: return 0;
         2'b11: return 2;
         default: return 1;
      endcase
   endfunction

   function automatic bit rise_path(input logic ci, input logic [1:0] l);
      return ci ? (l != 2'b00) : (l == 2'b11);
   endfunction

   task automatic check_now(input string tag);
      logic eb;
      logic ef;
      eb = (cfg_mode == 2'b00) ? (exp_pos % 8 == 1) : (exp_pos % 8 == 0);
      ef = (exp_pos == 0);
      checks++;
      if (bit_pos !== 10'(exp_pos) || frame_stb !== ef || byte_stb !== eb) begin
         fails++;
         $display("FAIL %s cycle %0d: bit_pos=%0d frame=%0b byte=%0b expected %0d %0b %0b",
                  tag, cnum, bit_pos, frame_stb, byte_stb, exp_pos, ef, eb);
      end
   endtask

   task automatic advance();
      cnum++;
      if (cnum == load_at) exp_pos = load_v;
      else                 exp_pos = (exp_pos >= n_len - 1) ? 0 : exp_pos + 1;
   endtask

   task automatic arm_load();
      load_at = cnum + 2;
      load_v  = 2 - dist_of(cfg_lead);
   endtask

   task automatic cyc(input bit act, input string tag);
      @(posedge clk);
      advance();
      #5 sync_in = act ^ cfg_sync_low;
      if (act) arm_load();
      #10 check_now(tag);
   endtask

   // pulse that covers only one of the two candidate edges
   task automatic narrow(input bit fall_only, input string tag);
      @(posedge clk);
      advance();
      if (fall_only) begin
         #5 sync_in = ~cfg_sync_low;
         #10 sync_in = cfg_sync_low;
         check_now(tag);
         if (!rise_path(cfg_clk_inv, cfg_lead)) arm_load();
      end else begin
         #5 sync_in = cfg_sync_low;
         #10 check_now(tag);
         sync_in = ~cfg_sync_low;
         if (rise_path(cfg_clk_inv, cfg_lead)) arm_load();
      end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic [1:0] l,
                           input logic sl, input logic ci);
      @(posedge clk);
      #5 rst_n = 1'b0;
      cfg_mode = m; cfg_lead = l; cfg_sync_low = sl; cfg_clk_inv = ci;
      sync_in = sl;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      cnum = 0; exp_pos = 0; load_at = -1; load_v = 0;
      n_len = len_of(m);
      #10 check_now("R1");
   endtask

   initial begin
      #3000000;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R2 R3 R4 R5 R6: free-running sweep of every frame length
      for (int m = 0; m < 4; m++) begin
         do_reset(2'(m), 2'b00, 1'b0, 1'b0);
         repeat (len_of(2'(m)) + 3) cyc(1'b0, (m == 0) ? "R2 R5 R6" : "R2 R4 R6");
      end

      // R7 R10: one pulse per mode, lead and clock inversion
      for (int ci = 0; ci < 2; ci++) begin
         for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 4; l++) begin
               do_reset(2'(m), 2'(l), 1'b0, 1'(ci));
               repeat (37) cyc(1'b0, "R6");
               cyc(1'b1, "R7");
               repeat (len_of(2'(m)) + 12) cyc(1'b0, "R7 R10");
            end
         end
      end

      // R8: active-low pulse; steady high line does nothing
      do_reset(2'b01, 2'b00, 1'b1, 1'b0);
      repeat (40) cyc(1'b0, "R8");
      cyc(1'b1, "R8");
      repeat (300) cyc(1'b0, "R8");

      // R9: half-width pulses at only one edge
      for (int ci = 0; ci < 2; ci++) begin
         for (int l = 0; l < 4; l++) begin
            do_reset(2'b01, 2'(l), 1'b0, 1'(ci));
            repeat (20) cyc(1'b0, "R9");
            narrow(1'b1, "R9");
            repeat (25) cyc(1'b0, "R9");
            narrow(1'b0, "R9");
            repeat (25) cyc(1'b0, "R9");
         end
      end

      // R11: second pulse mid-frame realigns
      do_reset(2'b10, 2'b11, 1'b0, 1'b0);
      repeat (100) cyc(1'b0, "R11");
      cyc(1'b1, "R11");
      repeat (150) cyc(1'b0, "R11");
      cyc(1'b1, "R11");
      repeat (600) cyc(1'b0, "R11");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule